// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single data rate SDRAM interface and brings the memory from power-up to a usable state. After a synchronous reset it holds the clock enable low, raises it partway through a programmable stabilization delay, and then issues a fixed series of single-cycle commands: precharge of all banks, two auto refreshes and a mode register load. Between commands it waits the programmed number of cycles and drives only no-operation commands.

All delays are given as cycle counts through parameters, so the same block serves any clock rate. A parameter chooses whether the mode register load comes before or after the refresh pair. The mode register contents come from an input port and are placed on the address bus in the cycle the load is issued. Once the last wait has run out, a done flag rises and stays high, and the command bus stays at no-operation, until the next reset.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: Counting the cycle in which reset is released as cycle 0, cycles 0 to PWRUP_CYC-1 carry only command-inhibit or no-operation, and the precharge appears in cycle PWRUP_CYC.
- R2: sd_cke is low from reset up to cycle CKE_RISE_CYC-1 and high from cycle CKE_RISE_CYC on; while it is low the bus carries command-inhibit, {cs_n,ras_n,cas_n,we_n} = 1111; once it is high, idle cycles carry no-operation, 0111.
- R3: Precharge-all is driven as {cs_n,ras_n,cas_n,we_n} = 0010 for one cycle with address bit AP_BIT (bit 10 by default) high, all other address bits low and bank bits zero; the next command follows exactly TRP_CYC cycles later with no-operation in between.
- R4: Each auto refresh is driven as 0001 for one cycle with address and bank zero, followed by exactly TRFC_CYC cycles before the next command or completion, with no-operation in between; N_REFRESH (default 2) refreshes are issued back to back this way.
- R5: The mode register load is driven as 0000 for one cycle with bank bits zero and the address equal to mode_word as presented at the preceding clock edge, followed by exactly TMRD_CYC cycles of wait with no-operation.
- R6: With MRS_FIRST = 0 the order is precharge, refreshes, mode load; with MRS_FIRST = 1 it is precharge, mode load, refreshes.
- R7: init_done is low until cycle PWRUP_CYC+TRP_CYC+TMRD_CYC+N_REFRESH*TRFC_CYC and high from then on, with sd_cke high and the bus at no-operation, address and bank zero, until reset.
- R8: A synchronous active-high reset returns, one edge later, sd_cke low, command-inhibit, address and bank zero and init_done low, and the whole sequence restarts from cycle 0 on release, at any point of the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset, restarts the sequence |
| mode_word | input | ADDR_W | Value loaded into the mode register |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus, carries the all-banks bit and the mode value |
| init_done | output | 1 | High once the sequence is complete |

## Verification
Every output is a register, so each value is due in a fixed cycle counted from reset release: cycle k shows the state after k rising edges, the precharge lands at PWRUP_CYC and every later command at the sum of the preceding waits. The bench releases reset on a falling edge, checks cycle 0 there and then checks every falling edge after it against a per-cycle expectation computed from the parameters, so no sample sits on an active edge. Reset effects are checked one edge after reset is seen, and aborted runs restart the cycle count from zero.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        PH_HOLD = 3'd0,
        PH_PRE  = 3'd1,
        PH_REF  = 3'd2,
        PH_MRS  = 3'd3,
        PH_DONE = 3'd4
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_INHIBIT = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_PRE     = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sd_cmd_t CMD_REF     = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sd_cmd_t CMD_MRS     = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    // Command that opens a phase
    function automatic sd_cmd_t phase_cmd(input phase_e ph);
        sd_cmd_t c;
        case (ph)
            PH_PRE:  c = CMD_PRE;
            PH_REF:  c = CMD_REF;
            PH_MRS:  c = CMD_MRS;
            default: c = CMD_NOP;
        endcase
        return c;
    endfunction

    // Step ordering; mrs_first picks where the mode load goes
    function automatic phase_e phase_after(input phase_e ph, input logic more_refs,
                                           input logic mrs_first);
        phase_e n;
        case (ph)
            PH_HOLD: n = PH_PRE;
            PH_PRE:  n = mrs_first ? PH_MRS : PH_REF;
            PH_REF:  n = more_refs ? PH_REF : (mrs_first ? PH_DONE : PH_MRS);
            PH_MRS:  n = mrs_first ? PH_REF : PH_DONE;
            default: n = PH_DONE;
        endcase
        return n;
    endfunction

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             expired
);

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned N_REFRESH = 2,
    parameter bit          MRS_FIRST = 1'b0,
    parameter int unsigned TRP_CYC   = 3,
    parameter int unsigned TRFC_CYC  = 7,
    parameter int unsigned TMRD_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             expired,
    output phase_e           phase_q,
    output phase_e           phase_d,
    output logic             start,
    output logic [CNT_W-1:0] dur_m1
);

    localparam int unsigned RC_W = $clog2(N_REFRESH + 1);
    localparam logic [RC_W-1:0] REF_LAST = RC_W'(N_REFRESH);

    logic [RC_W-1:0] refs_q;
    logic [RC_W-1:0] refs_d;
    logic            more_refs;

    assign more_refs = (refs_q < REF_LAST);
    assign start     = expired && (phase_q != PH_DONE);
    assign phase_d   = start ? phase_after(phase_q, more_refs, MRS_FIRST) : phase_q;
    assign refs_d    = (start && phase_d == PH_REF) ? refs_q + 1'b1 : refs_q;

    always_comb begin
        case (phase_d)
            PH_PRE:  dur_m1 = CNT_W'(TRP_CYC - 1);
            PH_REF:  dur_m1 = CNT_W'(TRFC_CYC - 1);
            PH_MRS:  dur_m1 = CNT_W'(TMRD_CYC - 1);
            default: dur_m1 = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HOLD;
            refs_q  <= '0;
        end else begin
            phase_q <= phase_d;
            refs_q  <= refs_d;
        end
    end

    AST_PHASE_WAITS: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_DONE && !expired) |=> (phase_q == $past(phase_q)))
        else $error("phase left before its wait ran out"); // R3

    AST_REF_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (refs_q <= REF_LAST))
        else $error("more refreshes than configured"); // R4

    AST_MRS_ORDER: assert property (@(posedge clk) disable iff (rst)
        (start && phase_d == PH_MRS) |-> (refs_q == (MRS_FIRST ? '0 : REF_LAST)))
        else $error("mode load out of order"); // R6

endmodule

// File: rtl/sdram_init_cmdout.sv
module sdram_init_cmdout
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned BA_W       = 2,
    parameter int unsigned AP_BIT     = 10,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned CKE_THRESH = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_d,
    input  logic              start,
    input  logic [CNT_W-1:0]  cnt_d,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cke,
    output sd_cmd_t           cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    logic              cke_n;
    sd_cmd_t           cmd_n;
    logic [ADDR_W-1:0] addr_n;
    logic              done_n;

    always_comb begin
        cke_n  = (phase_d != PH_HOLD) || (cnt_d <= CNT_W'(CKE_THRESH));
        cmd_n  = cke_n ? CMD_NOP : CMD_INHIBIT;
        addr_n = '0;
        if (start) begin
            cmd_n = phase_cmd(phase_d);
            if (phase_d == PH_PRE) addr_n[AP_BIT] = 1'b1;
            if (phase_d == PH_MRS) addr_n = mode_word;
        end
        done_n = (phase_d == PH_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke  <= 1'b0;
            cmd  <= CMD_INHIBIT;
            addr <= '0;
            ba   <= '0;
            done <= 1'b0;
        end else begin
            cke  <= cke_n;
            cmd  <= cmd_n;
            addr <= addr_n;
            ba   <= '0;
            done <= done_n;
        end
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned BA_W         = 2,
    parameter int unsigned AP_BIT       = 10,
    parameter int unsigned PWRUP_CYC    = 25000,
    parameter int unsigned CKE_RISE_CYC = 12500,
    parameter int unsigned TRP_CYC      = 5,
    parameter int unsigned TRFC_CYC     = 17,
    parameter int unsigned TMRD_CYC     = 2,
    parameter int unsigned N_REFRESH    = 2,
    parameter bit          MRS_FIRST    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);

    localparam int unsigned MAX_DUR    = max_of4(PWRUP_CYC, TRP_CYC, TRFC_CYC, TMRD_CYC);
    localparam int unsigned CNT_W      = $clog2(MAX_DUR + 1);
    localparam int unsigned CKE_THRESH = PWRUP_CYC - 1 - CKE_RISE_CYC;

    if (CKE_RISE_CYC < 1 || CKE_RISE_CYC >= PWRUP_CYC) begin : g_bad_cke
        $error("CKE_RISE_CYC must lie inside the power-up window");
    end
    if (TRP_CYC < 2 || TRFC_CYC < 2 || TMRD_CYC < 2 || N_REFRESH < 1) begin : g_bad_wait
        $error("waits must be at least two cycles and N_REFRESH at least one");
    end
    if (AP_BIT >= ADDR_W) begin : g_bad_ap
        $error("AP_BIT outside the address bus");
    end

    phase_e           phase_q;
    phase_e           phase_d;
    logic             start;
    logic             expired;
    logic [CNT_W-1:0] dur_m1;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    sd_cmd_t          cmd;

    sdram_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PWRUP_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (dur_m1),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .expired  (expired)
    );

    sdram_init_fsm #(
        .CNT_W     (CNT_W),
        .N_REFRESH (N_REFRESH),
        .MRS_FIRST (MRS_FIRST),
        .TRP_CYC   (TRP_CYC),
        .TRFC_CYC  (TRFC_CYC),
        .TMRD_CYC  (TMRD_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .expired (expired),
        .phase_q (phase_q),
        .phase_d (phase_d),
        .start   (start),
        .dur_m1  (dur_m1)
    );

    sdram_init_cmdout #(
        .ADDR_W     (ADDR_W),
        .BA_W       (BA_W),
        .AP_BIT     (AP_BIT),
        .CNT_W      (CNT_W),
        .CKE_THRESH (CKE_THRESH)
    ) u_cmdout (
        .clk       (clk),
        .rst       (rst),
        .phase_d   (phase_d),
        .start     (start),
        .cnt_d     (cnt_d),
        .mode_word (mode_word),
        .cke       (sd_cke),
        .cmd       (cmd),
        .ba        (sd_ba),
        .addr      (sd_addr),
        .done      (init_done)
    );

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;

    // Assertions on the pin-level behaviour
    logic [3:0] pins;
    logic       is_nop;
    logic       is_active;
    assign pins      = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_nop    = (pins == 4'b0111);
    assign is_active = !sd_cs_n && !is_nop;

    AST_CKE_LOW_INHIBITS: assert property (@(posedge clk) disable iff (rst)
        !sd_cke |-> sd_cs_n)
        else $error("command selected while CKE low"); // R2

    AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
        sd_cke |=> sd_cke)
        else $error("CKE dropped without reset"); // R2

    AST_HOLD_NO_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HOLD) |-> !is_active)
        else $error("command during power-up delay"); // R1

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        is_active |=> is_nop)
        else $error("command not followed by NOP"); // R3

    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0010) |-> (sd_addr[AP_BIT] && sd_ba == '0))
        else $error("precharge without all-banks bit"); // R3

    AST_MRS_BANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0000) |-> (sd_ba == '0))
        else $error("mode load with nonzero bank"); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done)
        else $error("done dropped without reset"); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (is_nop && sd_cke))
        else $error("bus not idle after done"); // R7

    AST_RESET_RESTART: assert property (@(posedge clk)
        rst |=> (!sd_cke && sd_cs_n && !init_done))
        else $error("reset did not return idle outputs"); // R8

endmodule

// File: tb/sdram_pwrup_seq_tb.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_tb;

    localparam int AW    = 12;
    localparam int BW    = 2;
    localparam int P     = 40;
    localparam int CKR   = 12;
    localparam int TRP   = 3;
    localparam int TRFC  = 7;
    localparam int TMRD  = 2;
    localparam int NREF  = 2;
    localparam int TDONE = P + TRP + TMRD + NREF * TRFC;

    typedef struct packed {
        logic          cke;
        logic [3:0]    cmd;
        logic [AW-1:0] addr;
        logic [BW-1:0] ba;
        logic          done;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mode_word = '0;

    exp_t act_a;
    exp_t act_b;

    int n_vec  = 0;
    int n_fail = 0;
    int n_cyc  = 0;

    always #2 clk = ~clk;

    sdram_pwrup_seq #(
        .ADDR_W(AW), .BA_W(BW), .AP_BIT(10), .PWRUP_CYC(P), .CKE_RISE_CYC(CKR),
        .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD), .N_REFRESH(NREF), .MRS_FIRST(1'b0)
    ) u_dut (
        .clk(clk), .rst(rst), .mode_word(mode_word),
        .sd_cke(act_a.cke), .sd_cs_n(act_a.cmd[3]), .sd_ras_n(act_a.cmd[2]),
        .sd_cas_n(act_a.cmd[1]), .sd_we_n(act_a.cmd[0]),
        .sd_ba(act_a.ba), .sd_addr(act_a.addr), .init_done(act_a.done)
    );

    sdram_pwrup_seq #(
        .ADDR_W(AW), .BA_W(BW), .AP_BIT(10), .PWRUP_CYC(P), .CKE_RISE_CYC(CKR),
        .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD), .N_REFRESH(NREF), .MRS_FIRST(1'b1)
    ) u_dut_mf (
        .clk(clk), .rst(rst), .mode_word(mode_word),
        .sd_cke(act_b.cke), .sd_cs_n(act_b.cmd[3]), .sd_ras_n(act_b.cmd[2]),
        .sd_cas_n(act_b.cmd[1]), .sd_we_n(act_b.cmd[0]),
        .sd_ba(act_b.ba), .sd_addr(act_b.addr), .init_done(act_b.done)
    );

    // Expected pins at cycle idx after release
    function automatic exp_t expect_at(input int idx, input bit mf, input logic [AW-1:0] mw);
        exp_t e;
        int t_mrs;
        int t_r0;
        e.cke  = (idx >= CKR);
        e.cmd  = e.cke ? 4'b0111 : 4'b1111;
        e.addr = '0;
        e.ba   = '0;
        if (mf) begin
            t_mrs = P + TRP;
            t_r0  = t_mrs + TMRD;
        end else begin
            t_r0  = P + TRP;
            t_mrs = t_r0 + NREF * TRFC;
        end
        if (idx == P) begin
            e.cmd = 4'b0010;
            e.addr[10] = 1'b1;
        end
        if (idx == t_mrs) begin
            e.cmd  = 4'b0000;
            e.addr = mw;
        end
        for (int i = 0; i < NREF; i++) begin
            if (idx == t_r0 + i * TRFC) e.cmd = 4'b0001;
        end
        e.done = (idx >= TDONE);
        return e;
    endfunction

    function automatic string tag_at(input int idx, input bit mf);
        if (idx < P) return "R1";
        if (idx < P + TRP) return "R3";
        if (idx >= TDONE) return "R7";
        if (mf) return "R6";
        if (idx >= P + TRP + NREF * TRFC) return "R5";
        return "R4";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_one(input int idx, input bit mf, input exp_t a);
        exp_t  e;
        string t;
        e = expect_at(idx, mf, mode_word);
        t = tag_at(idx, mf);
        chk(a.cke  === e.cke,  "R2", $sformatf("cke c%0d mf%0d", idx, mf), 32'(a.cke), 32'(e.cke));
        chk(a.cmd  === e.cmd,  t,    $sformatf("cmd c%0d mf%0d", idx, mf), 32'(a.cmd), 32'(e.cmd));
        chk(a.addr === e.addr, t,    $sformatf("addr c%0d mf%0d", idx, mf), 32'(a.addr), 32'(e.addr));
        chk(a.ba   === e.ba,   t,    $sformatf("ba c%0d mf%0d", idx, mf), 32'(a.ba), 32'(e.ba));
        chk(a.done === e.done, "R7", $sformatf("done c%0d mf%0d", idx, mf), 32'(a.done), 32'(e.done));
    endtask

    task automatic check_reset_state(input exp_t a, input string who);
        // R8: reset state on the pins
        chk(a.cke === 1'b0 && a.cmd === 4'b1111 && a.addr === '0 && a.ba === '0 && a.done === 1'b0,
            "R8", {"reset state ", who}, 32'(a), 32'({1'b0, 4'b1111, {AW{1'b0}}, {BW{1'b0}}, 1'b0}));
    endtask

    task automatic apply_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        repeat (cycles) @(negedge clk);
        check_reset_state(act_a, "order0");
        check_reset_state(act_b, "order1");
    endtask

    // Release reset and follow the sequence for ncyc cycles
    task automatic run_seq(input logic [AW-1:0] mw, input int ncyc);
        mode_word = mw;
        rst = 1'b0;
        check_one(0, 1'b0, act_a);
        check_one(0, 1'b1, act_b);
        for (int idx = 1; idx < ncyc; idx++) begin
            @(negedge clk);
            check_one(idx, 1'b0, act_a);
            check_one(idx, 1'b1, act_b);
        end
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc == 100000) begin
            n_fail++;
            $display("FAIL R7 watchdog: act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5D1A_2024));
        // R8: reset held from time zero
        repeat (3) @(negedge clk);
        check_reset_state(act_a, "order0 initial");
        check_reset_state(act_b, "order1 initial");

        // Directed full runs: R1 R2 R3 R4 R5 R6 R7
        run_seq({AW{1'b1}}, TDONE + 8);
        apply_reset(2);
        run_seq('0, TDONE + 8);
        apply_reset(1);
        run_seq(12'h237, TDONE + 8);

        // Directed aborts: R8 at precharge and just before completion
        apply_reset(1);
        run_seq(12'h0A5, P + 1);
        apply_reset(1);
        run_seq(12'h5A0, TDONE);
        apply_reset(3);
        run_seq(12'h3C3, CKR + 1);

        // Random runs: random mode value, random abort point, random reset length
        for (int k = 0; k < 10; k++) begin
            int len;
            apply_reset(1 + int'($urandom_range(3)));
            if ($urandom_range(2) == 0) len = TDONE + 6;
            else len = 1 + int'($urandom_range(TDONE + 4));
            run_seq(AW'($urandom), len);
        end

        apply_reset(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule